// File: doc/BRIEF.md
# Ranged Resistance Measurement Sequencer

This block is the digital controller for one resistance reading taken with an integrating front-end. A start request latches one of three one-hot range codes, and that code drives the current-mirror ratio and reference selection in the analog path. The block then cycles the integrating capacitor. Each cycle has a short phase where the capacitor is held discharged and the converter clock is stopped, followed by an integration window where the capacitor is released and the converter clock runs.

During each window the block reads converter samples. It subtracts each sample from the one taken just before it, so that fixed offsets in the analog chain drop out. Samples close to either rail are rejected, because the amplifier is not linear there. After 128 slope values have been collected, the block reports their floor average and pulses a completion flag for one cycle. Converting the slope to ohms is left to the consumer.

Top module: `res_meas_seq`

## Requirements
- R1: After reset: `cap_rst_o`=1, `adc_clk_en_o`=0, `mode_o`=3'b010, `done_o`=0 and `slope_avg_o`=0. An asynchronous reset during a run returns all outputs to these values.
- R2: When a start is accepted, `mode_o` takes the requested code if that code is 3'b001 (low range, 10 Ω–1 kΩ), 3'b010 (middle range, 1 kΩ–1 MΩ) or 3'b100 (high range, 1 MΩ–1 GΩ). Any other requested value yields 3'b010. `mode_o` always has exactly one bit set.
- R3: `cap_rst_o` and `adc_clk_en_o` are always complements of each other. Each discharge phase inside a run lasts exactly RST_CYC cycles. Samples offered while `adc_clk_en_o`=0 are ignored.
- R4: An integration window keeps `adc_clk_en_o`=1 for exactly WIN_CYC cycles, then returns to a discharge phase. The only exception is the window in which the run completes, which is cut short.
- R5: A slope value is the current accepted sample minus the previous accepted sample, as signed numbers. Both samples must lie in the same window and be adjacent among the accepted samples. Cycles with `samp_vld_i`=0 do not break adjacency.
- R6: A valid sample below CODE_LO or above CODE_HI (32 and 991 by default, both bounds inclusive) gives no slope value. It also breaks adjacency, so the next in-range sample has no predecessor.
- R7: After the 128th slope value, `slope_avg_o` is the signed sum of the 128 values shifted arithmetically right by 7 (a floor average). It holds that value until the next run completes.
- R8: `done_o` is high for exactly one cycle, in the cycle after the 128th slope value. At that point the block is idle, with `cap_rst_o`=1 and `adc_clk_en_o`=0.
- R9: A start request during a run is ignored. `mode_o` is unchanged for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a run; only accepted when idle |
| mode_req_i | input | 3 | Requested one-hot range code |
| samp_vld_i | input | 1 | Converter sample strobe |
| samp_i | input | ADC_W | Converter sample code |
| mode_o | output | 3 | Active one-hot range code to the analog path |
| cap_rst_o | output | 1 | Hold integrating capacitor discharged |
| adc_clk_en_o | output | 1 | Converter clock enable |
| slope_avg_o | output | ADC_W+1 | Signed averaged slope per sample |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach from the ports is a slope value that wrongly pairs samples from different windows, or pairs samples across a rejected near-rail sample. A plain ramp hides both errors, because the differences telescope back to the same total. To expose them, the stimulus restarts the ramp at its base value in every window. It also keeps the sample strobe high with a decoy code during every discharge phase. One further pattern inserts a rail code after every pair of in-range samples and then jumps the level, so any pairing across the rail code shifts the average away from its expected value of 7.

// File: rtl/rms_pkg.sv
package rms_pkg;
  typedef enum logic [2:0] {
    RNG_LOW  = 3'b001,
    RNG_MID  = 3'b010,
    RNG_HIGH = 3'b100
  } rng_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DISCH,
    ST_INTEG
  } st_e;

  function automatic logic [2:0] legal_mode(input logic [2:0] req);
    case (req)
      RNG_LOW, RNG_MID, RNG_HIGH: return req;
      default:                    return RNG_MID;
    endcase
  endfunction
endpackage

// File: rtl/rms_mode_reg.sv
module rms_mode_reg
  import rms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [2:0] req_i,
  output logic [2:0] mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= RNG_MID;
    else if (load_i) mode_o <= legal_mode(req_i);
  end
endmodule

// File: rtl/rms_ctrl.sv
module rms_ctrl
  import rms_pkg::*;
#(
  parameter int RST_CYC = 100,
  parameter int WIN_CYC = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic seg_clr_o,
  output logic cap_rst_o,
  output logic adc_en_o
);
  localparam int TMAX = (WIN_CYC > RST_CYC) ? WIN_CYC : RST_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  st_e           st_q;
  logic [TW-1:0] tmr_q;
  logic          win_end;

  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign win_end   = (st_q == ST_INTEG) && (tmr_q == TW'(WIN_CYC - 1));
  // clear the sample chain on every window exit and on a new run
  assign seg_clr_o = load_o || ((st_q == ST_INTEG) && (win_end || last_i));
  assign cap_rst_o = (st_q != ST_INTEG);
  assign adc_en_o  = (st_q == ST_INTEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (start_i) st_q <= ST_DISCH;
        end
        ST_DISCH: begin
          if (tmr_q == TW'(RST_CYC - 1)) begin
            st_q  <= ST_INTEG;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        ST_INTEG: begin
          if (last_i) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
          end else if (win_end) begin
            st_q  <= ST_DISCH;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rms_diff.sv
module rms_diff #(
  parameter int ADC_W   = 10,
  parameter int CODE_LO = 32,
  parameter int CODE_HI = 991
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic                    vld_i,
  input  logic [ADC_W-1:0]        code_i,
  output logic                    d_vld_o,
  output logic signed [ADC_W:0]   d_val_o
);
  logic [ADC_W-1:0] prev_q;
  logic             prev_vld_q;
  logic             in_rng;
  logic             take;

  assign in_rng  = (code_i >= ADC_W'(CODE_LO)) && (code_i <= ADC_W'(CODE_HI));
  assign take    = en_i && vld_i;
  assign d_vld_o = take && in_rng && prev_vld_q;
  assign d_val_o = $signed({1'b0, code_i}) - $signed({1'b0, prev_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else if (clr_i) begin
      prev_vld_q <= 1'b0;
    end else if (take) begin
      prev_vld_q <= in_rng;  // rail code breaks the chain
      if (in_rng) prev_q <= code_i;
    end
  end
endmodule

// File: rtl/rms_accum.sv
module rms_accum #(
  parameter int ADC_W    = 10,
  parameter int AVG_LOG2 = 7
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  d_vld_i,
  input  logic signed [ADC_W:0] d_val_i,
  output logic                  last_o,
  output logic signed [ADC_W:0] avg_o,
  output logic                  done_o
);
  localparam int AW = ADC_W + 1 + AVG_LOG2;

  logic [AVG_LOG2-1:0] cnt_q;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] sum_nxt;

  assign sum_nxt = acc_q + {{AVG_LOG2{d_val_i[ADC_W]}}, d_val_i};
  assign last_o  = d_vld_i && (cnt_q == {AVG_LOG2{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      avg_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (d_vld_i) begin
        if (last_o) begin
          avg_o  <= sum_nxt[AW-1:AVG_LOG2];  // floor divide
          done_o <= 1'b1;
          cnt_q  <= '0;
          acc_q  <= '0;
        end else begin
          acc_q <= sum_nxt;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/res_meas_seq.sv
module res_meas_seq #(
  parameter int ADC_W    = 10,
  parameter int AVG_LOG2 = 7,
  parameter int RST_CYC  = 100,
  parameter int WIN_CYC  = 10000,
  parameter int CODE_LO  = 32,
  parameter int CODE_HI  = 991
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [2:0]            mode_req_i,
  input  logic                  samp_vld_i,
  input  logic [ADC_W-1:0]      samp_i,
  output logic [2:0]            mode_o,
  output logic                  cap_rst_o,
  output logic                  adc_clk_en_o,
  output logic signed [ADC_W:0] slope_avg_o,
  output logic                  done_o
);
  logic                  load;
  logic                  seg_clr;
  logic                  last;
  logic                  d_vld;
  logic signed [ADC_W:0] d_val;

  rms_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .req_i  (mode_req_i),
    .mode_o (mode_o)
  );

  rms_ctrl #(.RST_CYC(RST_CYC), .WIN_CYC(WIN_CYC)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .last_i    (last),
    .load_o    (load),
    .seg_clr_o (seg_clr),
    .cap_rst_o (cap_rst_o),
    .adc_en_o  (adc_clk_en_o)
  );

  rms_diff #(.ADC_W(ADC_W), .CODE_LO(CODE_LO), .CODE_HI(CODE_HI)) u_diff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (seg_clr),
    .en_i    (adc_clk_en_o),
    .vld_i   (samp_vld_i),
    .code_i  (samp_i),
    .d_vld_o (d_vld),
    .d_val_o (d_val)
  );

  rms_accum #(.ADC_W(ADC_W), .AVG_LOG2(AVG_LOG2)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load),
    .d_vld_i (d_vld),
    .d_val_i (d_val),
    .last_o  (last),
    .avg_o   (slope_avg_o),
    .done_o  (done_o)
  );
endmodule

// File: rtl/res_meas_seq_chk.sv
module res_meas_seq_chk #(
  parameter int WIN_CYC = 10000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_o,
  input logic       cap_rst_o,
  input logic       adc_clk_en_o,
  input logic       done_o
);
  int unsigned win_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           win_cnt <= 0;
    else if (adc_clk_en_o) win_cnt <= win_cnt + 1;
    else                   win_cnt <= 0;
  end

  assert_phase_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_rst_o != adc_clk_en_o);

  assert_mode_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);

  assert_win_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt <= WIN_CYC);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cap_rst_o && !adc_clk_en_o));

  assert_mode_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_en_o |-> $stable(mode_o));
endmodule

bind res_meas_seq res_meas_seq_chk #(.WIN_CYC(WIN_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_o       (mode_o),
  .cap_rst_o    (cap_rst_o),
  .adc_clk_en_o (adc_clk_en_o),
  .done_o       (done_o)
);

// File: tb/res_meas_seq_tb.sv
module res_meas_seq_tb;
  localparam int ADC_W = 10;
  localparam int WIN   = 24;
  localparam int RSTC  = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [2:0]            mode_req = 3'b000;
  logic                  vld = 1'b0;
  logic [ADC_W-1:0]      samp = '0;
  logic [2:0]            mode_o;
  logic                  cap_rst_o;
  logic                  adc_clk_en_o;
  logic signed [ADC_W:0] slope_avg_o;
  logic                  done_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  res_meas_seq #(.ADC_W(ADC_W), .AVG_LOG2(7), .RST_CYC(RSTC), .WIN_CYC(WIN),
                 .CODE_LO(32), .CODE_HI(991)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .mode_req_i   (mode_req),
    .samp_vld_i   (vld),
    .samp_i       (samp),
    .mode_o       (mode_o),
    .cap_rst_o    (cap_rst_o),
    .adc_clk_en_o (adc_clk_en_o),
    .slope_avg_o  (slope_avg_o),
    .done_o       (done_o)
  );

  typedef struct packed {
    logic [2:0] req;
    logic [2:0] exp_mode;
    logic [1:0] kind;  // 0 ramp, 1 ramp with strobe gaps, 2 top rail, 3 bottom rail
    int         step;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'b001, 3'b001, 2'd0, 5},
    '{3'b100, 3'b100, 2'd1, 17},
    '{3'b011, 3'b010, 2'd0, -3},
    '{3'b000, 3'b010, 2'd0, 0},
    '{3'b010, 3'b010, 2'd2, 0},
    '{3'b110, 3'b010, 2'd3, 0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int code_for(input int kind, input int step, input int k);
    int g, p;
    if (kind < 2) return ((step < 0) ? 900 : 100) + step * k;
    g = k / 3;
    p = k % 3;
    if (p == 0) return 200 + 20 * g;
    if (p == 1) return 207 + 20 * g;
    return (kind == 2) ? 1015 : 3;
  endfunction

  task automatic run_vec(input vec_t v);
    int  k = 0, cyc = 0, hi = 0, lo = 0, exp_avg, tmp;
    bit  tog = 0, prev_en = 0, seen = 0;
    logic signed [ADC_W:0] held;
    exp_avg = (v.kind >= 2) ? 7 : v.step;
    @(negedge clk);
    mode_req = v.req;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mode_o == v.exp_mode, "R2 mode latch", int'(mode_o), int'(v.exp_mode));
    while (!done_o && cyc < 5000) begin
      if (adc_clk_en_o && !prev_en && seen)
        chk(lo == RSTC, "R3 discharge phase length", lo, RSTC);
      if (!adc_clk_en_o && prev_en) begin
        chk(hi == WIN, "R4 window length", hi, WIN);
        seen = 1;
      end
      start = (cyc == 40);  // R9: ignored mid-run request
      if (cyc == 40) mode_req = 3'b001 ^ v.exp_mode ^ 3'b001;
      if (cyc == 40) mode_req = (v.exp_mode == 3'b001) ? 3'b100 : 3'b001;
      if (adc_clk_en_o) begin
        if (!prev_en) hi = 0;
        hi++;
        if (v.kind == 1) begin tog = !tog; vld = tog; end
        else vld = 1'b1;
        if (vld) begin
          tmp  = code_for(int'(v.kind), v.step, k);
          samp = tmp[ADC_W-1:0];
          k++;
        end
      end else begin
        if (prev_en) lo = 0;
        lo++;
        k    = 0;
        vld  = 1'b1;
        samp = ADC_W'(500);  // decoy, must be ignored
      end
      prev_en = adc_clk_en_o;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done_o == 1'b1, "R8 done reached", int'(done_o), 1);
    chk(int'(slope_avg_o) == exp_avg, "R5 R6 R7 averaged slope", int'(slope_avg_o), exp_avg);
    chk(mode_o == v.exp_mode, "R9 mode held through run", int'(mode_o), int'(v.exp_mode));
    held = slope_avg_o;
    @(negedge clk);
    chk(!done_o && cap_rst_o && !adc_clk_en_o, "R8 single pulse then idle",
        int'({done_o, cap_rst_o, adc_clk_en_o}), 3'b010);
    for (int i = 0; i < 8; i++) begin
      vld  = 1'b1;
      samp = ADC_W'(100 + 97 * i);
      @(negedge clk);
    end
    chk(slope_avg_o == held, "R7 result held while idle", int'(slope_avg_o), int'(held));
    chk(!adc_clk_en_o, "R3 idle keeps converter clock off", int'(adc_clk_en_o), 0);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cap_rst_o == 1'b1, "R1 reset cap_rst", int'(cap_rst_o), 1);
    chk(adc_clk_en_o == 1'b0, "R1 reset clk_en", int'(adc_clk_en_o), 0);
    chk(mode_o == 3'b010, "R1 reset mode", int'(mode_o), 2);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    chk(slope_avg_o == '0, "R1 reset avg", int'(slope_avg_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R1: reset in the middle of a run
    mode_req = 3'b100;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cap_rst_o && !adc_clk_en_o, "R1 mid-run reset phase",
        int'({cap_rst_o, adc_clk_en_o}), 2);
    chk(mode_o == 3'b010, "R1 mid-run reset mode", int'(mode_o), 2);
    chk(slope_avg_o == '0 && !done_o, "R1 mid-run reset result", int'(slope_avg_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule